// File: doc/BRIEF.md
# Table-Driven Byte Mixing Engine

The engine scrambles a 128-bit state held as sixteen 8-bit mixing registers. A 32-bit linear feedback shift register, two 8-bit table pointers and a 256-byte constant lookup table drive the work. A run has either four or eight rounds. In each round every register is rebuilt from two table nibbles. A nibble is looked up again, with a shift-register step between tries, while it still equals the matching nibble of the register. The round ends by rotating the whole 128-bit state right by one bit and then reordering the registers under the table's control.

Software-free use is assumed. The surrounding logic writes the starting shift-register value, the registers, both pointers and the round-count choice with a load strobe, fires a start strobe and waits for the done strobe. It then reads the final registers, shift register and pointers from the result ports. How the starting values are chosen and how the result is used are left to the surrounding logic. The table image is a parameter, and the default image is computed. Rows 0 to 7 of the table must hold a permutation of 0..15 in their low nibbles.

Top module: `cave_mix_engine`

## Requirements
- R1: After reset `busy` and `done` are low and the shift register, all sixteen registers and both pointers read zero.
- R2: While idle, a cycle with `load` high and `start` low copies `ld_lfsr`, `ld_regs`, `ld_ptr_lo`, `ld_ptr_hi` and `ld_long` into the engine. The new values show on the result ports one cycle later. `load` is ignored whenever `start` is high or the engine is busy.
- R3: One shift-register step forms bit 22 XOR bit 2 XOR bit 1 XOR bit 0, shifts all 32 bits right by one and puts the formed bit at bit 31.
- R4: For register i, the low pointer gains (shift-register bits 31..24 XOR register i) and the low nibble of the table at that pointer is read. While that nibble equals the register's low nibble, the engine makes one step and tries again.
- R5: The high nibble is then found the same way with a fresh failure count. It uses the high pointer, shift-register bits 23..16 and the upper nibble of the table entry.
- R6: After FAIL_LIMIT (default 32) consecutive equal nibbles in one search, the search exits. Shift-register bits 7..0 are then incremented by one after the last step, and no carry goes into bit 8.
- R7: Register i becomes register i+1 XOR (high nibble OR low nibble). Register 15 uses the value register 0 held at the start of the round. After each register is rewritten, one step is made.
- R8: After register 15, the 128-bit value {reg0, reg1, ..., reg15} rotates right by one bit, so bit 0 of register 15 becomes bit 7 of register 0.
- R9: Rounds are numbered from N-1 down to 0, where N is 8 if `ld_long` was 1 and 4 otherwise. At the end of round k, register i moves to position (table[16*k+i] AND 0x0F).
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse, and in that cycle `busy` is already low. A `start` while busy is ignored.
- R11: All pointer arithmetic wraps modulo 256, and the final pointer values are readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load strobe for the starting values |
| ld_lfsr | input | 32 | Starting shift-register value |
| ld_regs | input | 128 | Starting registers, register 0 in bits 127..120 |
| ld_ptr_lo | input | 8 | Starting low-nibble table pointer |
| ld_ptr_hi | input | 8 | Starting high-nibble table pointer |
| ld_long | input | 1 | 1 selects eight rounds, 0 selects four |
| start | input | 1 | Run request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| lfsr_o | output | 32 | Current shift-register value |
| regs_o | output | 128 | Current registers, register 0 in bits 127..120 |
| ptr_lo_o | output | 8 | Current low-nibble pointer |
| ptr_hi_o | output | 8 | Current high-nibble pointer |

## Verification
The assertions take for granted that `start` is a pulse and that the table image gives a true permutation in rows 0 to 7. With any other image the register moves would collide. The bench keeps the default computed image and only pulses `start`. It replays the algorithm in its own model over many random starting loads, with both round counts. A second instance uses a failure limit of two so that the forced-exit path is actually reached. A few runs also apply `load` or `start` in the middle of a run, or both strobes in the same cycle, to show that these are ignored.

// File: rtl/cave_mix_pkg.sv
package cave_mix_pkg;
    localparam int NREG   = 16;
    localparam int RW     = 8;
    localparam int LW     = 32;
    localparam int ROM_N  = 256;
    localparam int ROM_BITS = ROM_N * RW;

    typedef enum logic [3:0] {
        S_IDLE = 4'd0,
        S_LO_A = 4'd1,
        S_LO_C = 4'd2,
        S_HI_A = 4'd3,
        S_HI_C = 4'd4,
        S_UPD  = 4'd5,
        S_ROT  = 4'd6,
        S_PM_A = 4'd7,
        S_PM_C = 4'd8
    } state_e;

    // Default table: low nibbles of every row form a permutation of 0..15.
    function automatic logic [ROM_BITS-1:0] build_rom();
        logic [ROM_BITS-1:0] img;
        int lo;
        int hi;
        img = '0;
        for (int a = 0; a < ROM_N; a++) begin
            lo = ((a % 16) * 5 + (a / 16) * 3 + 7) % 16;
            hi = ((a * 11) + (a / 16) * 7 + (a % 7) * 5 + 9) % 16;
            img[a*RW +: RW] = RW'(hi * 16 + lo);
        end
        return img;
    endfunction
endpackage

// File: rtl/cave_mix_rom.sv
module cave_mix_rom #(
    parameter logic [cave_mix_pkg::ROM_BITS-1:0] IMAGE = cave_mix_pkg::build_rom()
) (
    input  logic       clk,
    input  logic [7:0] addr,
    output logic [7:0] data
);
    always_ff @(posedge clk) begin
        data <= IMAGE[{addr, 3'b000} +: 8];
    end
endmodule

// File: rtl/cave_mix_lfsr_step.sv
module cave_mix_lfsr_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic fb;
    always_comb begin
        fb  = cur[22] ^ cur[2] ^ cur[1] ^ cur[0];
        nxt = {fb, cur[W-1:1]};
    end
endmodule

// File: rtl/cave_mix_engine.sv
module cave_mix_engine
    import cave_mix_pkg::*;
#(
    parameter int FAIL_LIMIT = 32,
    parameter logic [ROM_BITS-1:0] ROM_IMAGE = build_rom()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LW-1:0]    ld_lfsr,
    input  logic [NREG*RW-1:0] ld_regs,
    input  logic [RW-1:0]    ld_ptr_lo,
    input  logic [RW-1:0]    ld_ptr_hi,
    input  logic             ld_long,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [LW-1:0]    lfsr_o,
    output logic [NREG*RW-1:0] regs_o,
    output logic [RW-1:0]    ptr_lo_o,
    output logic [RW-1:0]    ptr_hi_o
);
    localparam int FW = (FAIL_LIMIT > 2) ? $clog2(FAIL_LIMIT) : 1;
    localparam int IW = $clog2(NREG);
    localparam logic [FW-1:0] FAIL_LAST = FW'(FAIL_LIMIT - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(NREG - 1);

    typedef struct packed {
        state_e                     st;
        logic [LW-1:0]              lfsr;
        logic [RW-1:0]              ptr_lo;
        logic [RW-1:0]              ptr_hi;
        logic [0:NREG-1][RW-1:0]    regs;
        logic [0:NREG-1][RW-1:0]    tmp;
        logic [RW-1:0]              r0_save;
        logic [IW-1:0]              ridx;
        logic [2:0]                 round;
        logic                       long_run;
        logic [FW-1:0]              fail;
        logic [3:0]                 lo_nib;
        logic                       done;
    } eng_t;

    eng_t q, d;

    logic [7:0]    rom_addr;
    logic [7:0]    rom_q;
    logic [LW-1:0] step_out;
    logic [LW-1:0] step_bump;
    logic [RW-1:0] sum_lo;
    logic [RW-1:0] sum_hi;
    logic [RW-1:0] cur_reg;
    logic [IW-1:0] next_idx;
    logic [NREG*RW-1:0] rot_v;
    logic [FW-1:0] fail_cnt;

    cave_mix_rom #(.IMAGE(ROM_IMAGE)) u_rom (
        .clk  (clk),
        .addr (rom_addr),
        .data (rom_q)
    );

    cave_mix_lfsr_step #(.W(LW)) u_step (
        .cur (q.lfsr),
        .nxt (step_out)
    );

    always_comb begin
        cur_reg   = q.regs[q.ridx];
        next_idx  = q.ridx + 1'b1;
        sum_lo    = q.ptr_lo + (q.lfsr[31:24] ^ cur_reg);
        sum_hi    = q.ptr_hi + (q.lfsr[23:16] ^ cur_reg);
        step_bump = {step_out[LW-1:8], step_out[7:0] + 8'd1};
        rot_v     = q.regs;
        rot_v     = {rot_v[0], rot_v[NREG*RW-1:1]};
        case (q.st)
            S_LO_A:  rom_addr = sum_lo;
            S_HI_A:  rom_addr = sum_hi;
            S_PM_A:  rom_addr = {1'b0, q.round, q.ridx};
            default: rom_addr = '0;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st      = S_LO_A;
                    d.ridx    = '0;
                    d.round   = q.long_run ? 3'd7 : 3'd3;
                    d.r0_save = q.regs[0];
                    d.fail    = '0;
                end else if (load) begin
                    d.lfsr     = ld_lfsr;
                    d.regs     = ld_regs;
                    d.ptr_lo   = ld_ptr_lo;
                    d.ptr_hi   = ld_ptr_hi;
                    d.long_run = ld_long;
                end
            end
            S_LO_A: begin
                d.ptr_lo = sum_lo;
                d.st     = S_LO_C;
            end
            S_LO_C: begin
                d.lo_nib = rom_q[3:0];
                if (rom_q[3:0] == cur_reg[3:0]) begin
                    if (q.fail == FAIL_LAST) begin
                        d.lfsr = step_bump;
                        d.fail = '0;
                        d.st   = S_HI_A;
                    end else begin
                        d.lfsr = step_out;
                        d.fail = q.fail + 1'b1;
                        d.st   = S_LO_A;
                    end
                end else begin
                    d.fail = '0;
                    d.st   = S_HI_A;
                end
            end
            S_HI_A: begin
                d.ptr_hi = sum_hi;
                d.st     = S_HI_C;
            end
            S_HI_C: begin
                if ((rom_q[7:4] == cur_reg[7:4]) && (q.fail != FAIL_LAST)) begin
                    d.lfsr = step_out;
                    d.fail = q.fail + 1'b1;
                    d.st   = S_HI_A;
                end else begin
                    if (rom_q[7:4] == cur_reg[7:4]) begin
                        d.lfsr = step_bump;
                    end
                    d.fail = '0;
                    d.regs[q.ridx] = ((q.ridx == IDX_LAST) ? q.r0_save : q.regs[next_idx])
                                     ^ {rom_q[7:4], q.lo_nib};
                    d.st = S_UPD;
                end
            end
            S_UPD: begin
                d.lfsr = step_out;
                if (q.ridx == IDX_LAST) begin
                    d.st = S_ROT;
                end else begin
                    d.ridx = next_idx;
                    d.st   = S_LO_A;
                end
            end
            S_ROT: begin
                d.regs = rot_v;
                d.ridx = '0;
                d.st   = S_PM_A;
            end
            S_PM_A: begin
                d.st = S_PM_C;
            end
            S_PM_C: begin
                d.tmp[rom_q[3:0]] = q.regs[q.ridx];
                if (q.ridx == IDX_LAST) begin
                    d.regs = d.tmp;
                    d.ridx = '0;
                    if (q.round == 3'd0) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.round   = q.round - 1'b1;
                        d.r0_save = d.tmp[0];
                        d.st      = S_LO_A;
                    end
                end else begin
                    d.ridx = next_idx;
                    d.st   = S_PM_A;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fail_cnt = q.fail;
    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign lfsr_o   = q.lfsr;
    assign regs_o   = q.regs;
    assign ptr_lo_o = q.ptr_lo;
    assign ptr_hi_o = q.ptr_hi;
endmodule

// File: rtl/cave_mix_checker.sv
module cave_mix_checker #(
    parameter int FAIL_LIMIT = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load,
    input logic         start,
    input logic [31:0]  ld_lfsr,
    input logic [127:0] ld_regs,
    input logic         busy,
    input logic         done,
    input logic [31:0]  lfsr_o,
    input logic [127:0] regs_o,
    input logic [7:0]   ptr_lo_o,
    input logic [7:0]   ptr_hi_o,
    input logic [((FAIL_LIMIT > 2) ? $clog2(FAIL_LIMIT) : 1)-1:0] fail_cnt
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done));

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !start && !busy) |=> (lfsr_o == $past(ld_lfsr) && regs_o == $past(ld_regs)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load && !start) |=> ($stable(lfsr_o) && $stable(regs_o)
                                        && $stable(ptr_lo_o) && $stable(ptr_hi_o)));

    p_idle_no_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fail_cnt == '0));

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(busy)));
endmodule

bind cave_mix_engine cave_mix_checker #(.FAIL_LIMIT(FAIL_LIMIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .start    (start),
    .ld_lfsr  (ld_lfsr),
    .ld_regs  (ld_regs),
    .busy     (busy),
    .done     (done),
    .lfsr_o   (lfsr_o),
    .regs_o   (regs_o),
    .ptr_lo_o (ptr_lo_o),
    .ptr_hi_o (ptr_hi_o),
    .fail_cnt (fail_cnt)
);

// File: tb/sim_cave_mix_engine.sv
module sim_cave_mix_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [2047:0] IMG = cave_mix_pkg::build_rom();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [31:0] ld_lfsr = '0;
    logic [127:0] ld_regs = '0;
    logic [7:0] ld_ptr_lo = '0;
    logic [7:0] ld_ptr_hi = '0;
    logic ld_long = 1'b0;
    logic start0 = 1'b0;
    logic start1 = 1'b0;

    logic b0, d0, b1, d1;
    logic [31:0] l0, l1;
    logic [127:0] r0, r1;
    logic [7:0] pl0, ph0, pl1, ph1;

    int checks = 0;
    int errors = 0;
    int forced = 0;

    logic [31:0] m_l;
    logic [7:0]  m_r [16];
    logic [7:0]  m_pl, m_ph;
    logic        m_long;

    always #(CLK_PERIOD/2) clk = ~clk;

    cave_mix_engine u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_lfsr(ld_lfsr), .ld_regs(ld_regs),
        .ld_ptr_lo(ld_ptr_lo), .ld_ptr_hi(ld_ptr_hi), .ld_long(ld_long), .start(start0),
        .busy(b0), .done(d0), .lfsr_o(l0), .regs_o(r0), .ptr_lo_o(pl0), .ptr_hi_o(ph0)
    );

    cave_mix_engine #(.FAIL_LIMIT(2)) u1 (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_lfsr(ld_lfsr), .ld_regs(ld_regs),
        .ld_ptr_lo(ld_ptr_lo), .ld_ptr_hi(ld_ptr_hi), .ld_long(ld_long), .start(start1),
        .busy(b1), .done(d1), .lfsr_o(l1), .regs_o(r1), .ptr_lo_o(pl1), .ptr_hi_o(ph1)
    );

    function automatic logic [7:0] tbl(input int a);
        return IMG[a*8 +: 8];
    endfunction

    function automatic logic [31:0] stp(input logic [31:0] v);
        return {v[22] ^ v[2] ^ v[1] ^ v[0], v[31:1]};
    endfunction

    function automatic logic [127:0] m_pack();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[127-8*i -: 8] = m_r[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model of the whole run (R3 R4 R5 R6 R7 R8 R9 R11)
    task automatic model_run(input int limit);
        logic [7:0] t0, lo, hi;
        logic [7:0] tp [16];
        logic [127:0] v;
        int fc;
        for (int rnd = (m_long ? 7 : 3); rnd >= 0; rnd--) begin
            t0 = m_r[0];
            for (int i = 0; i < 16; i++) begin
                fc = 0;
                lo = 8'h00;
                hi = 8'h00;
                while (1) begin
                    m_pl = 8'(m_pl + (m_l[31:24] ^ m_r[i]));
                    lo = tbl(int'(m_pl)) & 8'h0F;
                    if (lo == (m_r[i] & 8'h0F)) begin
                        m_l = stp(m_l);
                        fc++;
                        if (fc == limit) begin
                            m_l[7:0] = m_l[7:0] + 8'd1;
                            forced++;
                            break;
                        end
                    end else break;
                end
                fc = 0;
                while (1) begin
                    m_ph = 8'(m_ph + (m_l[23:16] ^ m_r[i]));
                    hi = tbl(int'(m_ph)) & 8'hF0;
                    if (hi == (m_r[i] & 8'hF0)) begin
                        m_l = stp(m_l);
                        fc++;
                        if (fc == limit) begin
                            m_l[7:0] = m_l[7:0] + 8'd1;
                            forced++;
                            break;
                        end
                    end else break;
                end
                m_r[i] = ((i == 15) ? t0 : m_r[i+1]) ^ (lo | hi);
                m_l = stp(m_l);
            end
            v = m_pack();
            v = {v[0], v[127:1]};
            for (int i = 0; i < 16; i++) m_r[i] = v[127-8*i -: 8];
            for (int i = 0; i < 16; i++) tp[tbl(16*rnd + i) & 8'h0F] = m_r[i];
            for (int i = 0; i < 16; i++) m_r[i] = tp[i];
        end
    endtask

    task automatic rand_load_values(input bit lng);
        ld_lfsr   = $urandom;
        ld_regs   = {$urandom, $urandom, $urandom, $urandom};
        ld_ptr_lo = 8'($urandom);
        ld_ptr_hi = 8'($urandom);
        ld_long   = lng;
    endtask

    // mode 0 plain, 1 load mid-run, 2 start mid-run, 3 load and start together
    task automatic run_case(input bit which, input bit lng, input int mode);
        bit seen;
        @(negedge clk);
        rand_load_values(lng);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_l = ld_lfsr; m_pl = ld_ptr_lo; m_ph = ld_ptr_hi; m_long = lng;
        for (int i = 0; i < 16; i++) m_r[i] = ld_regs[127-8*i -: 8];
        check((which ? l1 : l0) == m_l && (which ? r1 : r0) == m_pack()
              && (which ? pl1 : pl0) == m_pl && (which ? ph1 : ph0) == m_ph,
              "R2 load readback", which ? r1 : r0, m_pack());
        if (mode == 3) begin
            rand_load_values(~lng);
            load = 1'b1;
        end
        if (which) start1 = 1'b1; else start0 = 1'b1;
        @(negedge clk);
        load = 1'b0; start0 = 1'b0; start1 = 1'b0;
        check((which ? b1 : b0) == 1'b1, "R10 busy after start",
              128'(which ? b1 : b0), 128'd1);
        model_run(which ? 2 : 32);
        seen = 1'b0;
        for (int c = 0; c < 6000 && !seen; c++) begin
            if (mode == 1 && c == 20) begin
                rand_load_values(~lng);
                load = 1'b1;
            end else if (mode == 2 && c == 20) begin
                if (which) start1 = 1'b1; else start0 = 1'b1;
            end else begin
                load = 1'b0; start0 = 1'b0; start1 = 1'b0;
            end
            @(negedge clk);
            if (which ? d1 : d0) seen = 1'b1;
        end
        load = 1'b0; start0 = 1'b0; start1 = 1'b0;
        check(seen, "R10 done within bound", 128'(seen), 128'd1);
        check((which ? r1 : r0) == m_pack(),
              "R4 R5 R7 R8 R9 final registers", which ? r1 : r0, m_pack());
        check((which ? l1 : l0) == m_l, "R3 R6 final shift register",
              128'(which ? l1 : l0), 128'(m_l));
        check((which ? pl1 : pl0) == m_pl && (which ? ph1 : ph0) == m_ph,
              "R11 final pointers", {(which ? pl1 : pl0), (which ? ph1 : ph0)}, {m_pl, m_ph});
        check((which ? b1 : b0) == 1'b0, "R10 busy low with done",
              128'(which ? b1 : b0), 128'd0);
        @(negedge clk);
        check((which ? d1 : d0) == 1'b0 && (which ? b1 : b0) == 1'b0,
              "R10 single done pulse, no rerun", 128'(which ? d1 : d0), 128'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(b0 == 1'b0 && d0 == 1'b0 && l0 == '0 && r0 == '0 && pl0 == '0 && ph0 == '0,
              "R1 reset state", r0, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(b0 == 1'b0 && d0 == 1'b0 && l0 == '0 && r0 == '0,
              "R1 state after reset release", {b0, d0, l0}, 128'd0);
        // plain runs, both round counts (R9)
        for (int k = 0; k < 24; k++) run_case(1'b0, k[0], 0);
        // load mid-run, start mid-run, load with start (R2, R10)
        run_case(1'b0, 1'b1, 1);
        run_case(1'b0, 1'b0, 1);
        run_case(1'b0, 1'b1, 2);
        run_case(1'b0, 1'b0, 2);
        run_case(1'b0, 1'b1, 3);
        run_case(1'b0, 1'b0, 3);
        // short failure limit reaches the forced exit (R6)
        forced = 0;
        for (int k = 0; k < 16; k++) run_case(1'b1, k[0], 0);
        check(forced > 0, "R6 forced exit exercised", 128'(forced), 128'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule